// File: doc/BRIEF.md
# Conditional-Sum Binary Adder

This block adds two unsigned operands and a carry input and returns the sum and the carry output. It has no clock and no state. It is meant for a datapath that needs a wide adder with a short carry path, and where extra area is acceptable.

The operands are split into a lower part and an upper part. The lower part is added with the incoming carry. The upper part is added twice at the same time: one copy assumes a carry of 0 and the other assumes a carry of 1. The carry out of the lower part then picks the correct upper copy, both its sum bits and its carry. Each part is split again the same way until it is no wider than a leaf width. A leaf is a short ripple chain of full adders.

Top module: `csa_adder`

## Requirements
- R1: For every input, `{carry_o, sum_o}` equals `a_i + b_i + carry_i`, computed at WIDTH+1 bits.
- R2: With both operands zero and `carry_i`=1, `sum_o` is 1 and `carry_o` is 0. With all inputs zero, both outputs are zero.
- R3: In every split, the upper copy that assumes carry 1 gives a result exactly one greater than the copy that assumes carry 0. The carry-1 copy is never below the carry-0 copy.
- R4: All ones plus 1 (with `carry_i`=0) gives a sum of zero and `carry_o`=1. All ones plus all ones plus a carry-in of 1 gives all ones and `carry_o`=1.
- R5: An incoming carry of 1 added to an all-ones operand and a zero operand passes through every leaf and every select. The sum is zero and `carry_o` is 1.
- R6: A leaf adds in ripple fashion: bit i of the sum is a^b^c, and the next carry is (a&b)|(c&(a^b)). With a leaf width of 1 this is a full adder, and the whole tree stays exact.
- R7: WIDTH and the leaf width are parameters. When a width is odd, the lower part gets floor(w/2) bits and the upper part gets the rest. Widths that are not powers of two (for example 13 with leaf 3) give exact results.
- R8: Alternating patterns: 0x5555...5 + 0xAAAA...A gives all ones with no carry. The same sum with `carry_i`=1 gives zero with `carry_o`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| carry_i | input | 1 | Carry into bit 0 |
| sum_o | output | WIDTH | Sum bits |
| carry_o | output | 1 | Carry out of the top bit |

## Verification
The hardest case to reach from the ports is a carry that starts at bit 0 and must pass through every leaf and every select level, so that each select in the tree picks its carry-1 copy. Random operands almost never produce it. The bench therefore drives it on purpose: an all-ones operand with a zero or one partner and a carry input. It also runs an exhaustive sweep of a 5-bit, leaf-1 instance, which reaches every select combination of a tree of bare full adders.

// File: rtl/csa_pkg.sv
package csa_pkg;
  // lower part takes floor(w/2); upper part takes the remainder
  function automatic int lo_width(input int w);
    return w / 2;
  endfunction
  function automatic int hi_width(input int w);
    return w - (w / 2);
  endfunction
endpackage

// File: rtl/csa_leaf.sv
module csa_leaf #(
  parameter int W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         ci_i,
  output logic [W-1:0] sum_o,
  output logic         co_o
);
  logic [W:0] c;
  assign c[0] = ci_i;

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic p;
    assign p          = a_i[i] ^ b_i[i];
    assign sum_o[i]   = p ^ c[i];
    assign c[i+1]     = (a_i[i] & b_i[i]) | (c[i] & p);
  end

  assign co_o = c[W];

  always_comb begin
    if (!$isunknown({a_i, b_i, ci_i})) begin
      assert_leaf_exact_R6: assert ({co_o, sum_o} == ({1'b0, a_i} + {1'b0, b_i} + (W+1)'(ci_i)))
        else $error("leaf ripple mismatch");
    end
  end
endmodule

// File: rtl/csa_node.sv
module csa_node #(
  parameter int W      = 64,
  parameter int LEAF_W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         ci_i,
  output logic [W-1:0] sum_o,
  output logic         co_o
);
  import csa_pkg::*;
  localparam int WL = lo_width(W);
  localparam int WH = hi_width(W);

  if (W <= LEAF_W || W < 2) begin : g_leaf
    csa_leaf #(.W(W)) leaf_i (
      .a_i(a_i), .b_i(b_i), .ci_i(ci_i), .sum_o(sum_o), .co_o(co_o)
    );
  end else begin : g_split
    logic [WL-1:0] sum_lo;
    logic          co_lo;
    logic [WH-1:0] sum_h0, sum_h1;
    logic          co_h0, co_h1;

    csa_node #(.W(WL), .LEAF_W(LEAF_W)) lo_i (
      .a_i(a_i[WL-1:0]), .b_i(b_i[WL-1:0]), .ci_i(ci_i),
      .sum_o(sum_lo), .co_o(co_lo)
    );
    // speculative upper copies
    csa_node #(.W(WH), .LEAF_W(LEAF_W)) hi0_i (
      .a_i(a_i[W-1:WL]), .b_i(b_i[W-1:WL]), .ci_i(1'b0),
      .sum_o(sum_h0), .co_o(co_h0)
    );
    csa_node #(.W(WH), .LEAF_W(LEAF_W)) hi1_i (
      .a_i(a_i[W-1:WL]), .b_i(b_i[W-1:WL]), .ci_i(1'b1),
      .sum_o(sum_h1), .co_o(co_h1)
    );

    assign sum_o = co_lo ? {sum_h1, sum_lo} : {sum_h0, sum_lo};
    assign co_o  = co_lo ? co_h1 : co_h0;

    always_comb begin
      if (!$isunknown({a_i, b_i})) begin
        assert_copies_differ_by_one_R3: assert ({co_h1, sum_h1} == ({co_h0, sum_h0} + (WH+1)'(1)))
          else $error("upper copies not one apart");
        assert_carry_copy_order_R3: assert (!co_h0 || co_h1)
          else $error("carry-0 copy carries while carry-1 copy does not");
      end
    end
  end
endmodule

// File: rtl/csa_adder.sv
module csa_adder #(
  parameter int WIDTH  = 64,
  parameter int LEAF_W = 4
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             carry_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             carry_o
);
  csa_node #(.W(WIDTH), .LEAF_W(LEAF_W)) root_i (
    .a_i(a_i), .b_i(b_i), .ci_i(carry_i), .sum_o(sum_o), .co_o(carry_o)
  );

  always_comb begin
    if (!$isunknown({a_i, b_i, carry_i})) begin
      assert_sum_exact_R1: assert ({carry_o, sum_o} ==
                                   ({1'b0, a_i} + {1'b0, b_i} + (WIDTH+1)'(carry_i)))
        else $error("adder result mismatch");
    end
  end
endmodule

// File: tb/csa_adder_tb.sv
`timescale 1ns/1ps
module csa_adder_tb_top;
  localparam int W  = 64;
  localparam int WS = 13;
  localparam int WT = 5;
  localparam logic [W-1:0] ONES = '1;
  localparam logic [W-1:0] ALT5 = 64'h5555_5555_5555_5555;
  localparam logic [W-1:0] ALTA = 64'hAAAA_AAAA_AAAA_AAAA;

  localparam int NV = 8;
  localparam logic [W-1:0] TAB_A [NV] = '{64'h0, 64'h0, ONES, ALT5, ALT5, ONES, 64'h0000_0000_FFFF_FFFF, 64'h8000_0000_0000_0000};
  localparam logic [W-1:0] TAB_B [NV] = '{64'h0, 64'h0, 64'h1, ALTA, ALTA, ONES, 64'h0000_0000_0000_0001, 64'h8000_0000_0000_0000};
  localparam logic         TAB_C [NV] = '{1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0};

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic [W-1:0]  a, b, s;
  logic          ci, co;
  logic [WS-1:0] as, bs, ss;
  logic          cis, cos;
  logic [WT-1:0] at, bt, st;
  logic          cit, cot;

  csa_adder #(.WIDTH(W), .LEAF_W(4)) dut_i (
    .a_i(a), .b_i(b), .carry_i(ci), .sum_o(s), .carry_o(co));
  csa_adder #(.WIDTH(WS), .LEAF_W(3)) dut_odd_i (
    .a_i(as), .b_i(bs), .carry_i(cis), .sum_o(ss), .carry_o(cos));
  csa_adder #(.WIDTH(WT), .LEAF_W(1)) dut_bit_i (
    .a_i(at), .b_i(bt), .carry_i(cit), .sum_o(st), .carry_o(cot));

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 1'b0;

  task automatic check(input string req, input logic [W:0] act, input logic [W:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [W-1:0] x, input logic [W-1:0] y, input logic c);
    @(posedge clk);
    a = x; b = y; ci = c;
    @(negedge clk);
  endtask

  function automatic logic [W:0] ref_sum(input logic [W-1:0] x, input logic [W-1:0] y, input logic c);
    return {1'b0, x} + {1'b0, y} + (W+1)'(c);
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    a = '0; b = '0; ci = 1'b0;
    as = '0; bs = '0; cis = 1'b0;
    at = '0; bt = '0; cit = 1'b0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R2: idle zero state
    check("R2 zero inputs", {co, s}, '0);

    // R1 table walk
    for (int i = 0; i < NV; i++) begin
      apply(TAB_A[i], TAB_B[i], TAB_C[i]);
      check("R1 table", {co, s}, ref_sum(TAB_A[i], TAB_B[i], TAB_C[i]));
    end

    // R2 zero plus carry-in
    apply('0, '0, 1'b1);
    check("R2 carry only", {co, s}, {1'b0, 64'h1});
    // R4 corners
    apply(ONES, 64'h1, 1'b0);
    check("R4 ones plus one", {co, s}, {1'b1, 64'h0});
    apply(ONES, ONES, 1'b1);
    check("R4 ones plus ones plus one", {co, s}, {1'b1, ONES});
    // R5 carry-in through every leaf, both operand orders
    apply(ONES, '0, 1'b1);
    check("R5 full ripple", {co, s}, {1'b1, 64'h0});
    apply('0, ONES, 1'b1);
    check("R5 full ripple swapped", {co, s}, {1'b1, 64'h0});
    // R8 alternating
    apply(ALT5, ALTA, 1'b0);
    check("R8 alternating", {co, s}, {1'b0, ONES});
    apply(ALTA, ALT5, 1'b1);
    check("R8 alternating carry", {co, s}, {1'b1, 64'h0});

    // R3: the carry-in of a lower part decides the upper result; step over a split boundary
    apply(64'h0000_0000_FFFF_FFFF, '0, 1'b1);
    check("R3 select at half boundary", {co, s}, {1'b0, 64'h0000_0001_0000_0000});

    // R1 random
    for (int i = 0; i < 3000; i++) begin
      logic [W-1:0] x, y;
      logic c;
      x = {$urandom(), $urandom()};
      y = {$urandom(), $urandom()};
      c = 1'($urandom());
      apply(x, y, c);
      check("R1 random", {co, s}, ref_sum(x, y, c));
    end

    // R7 odd width, odd leaf
    for (int i = 0; i < 2000; i++) begin
      logic [WS-1:0] x, y;
      logic c;
      x = WS'($urandom()); y = WS'($urandom()); c = 1'($urandom());
      @(posedge clk);
      as = x; bs = y; cis = c;
      @(negedge clk);
      check("R7 width 13", {{(W-WS){1'b0}}, cos, ss},
            (W+1)'({1'b0, x} + {1'b0, y} + (WS+1)'(c)));
    end
    @(posedge clk); as = '1; bs = '0; cis = 1'b1; @(negedge clk);
    check("R7 width 13 full ripple", {{(W-WS){1'b0}}, cos, ss}, (W+1)'(14'h2000));

    // R6 exhaustive leaf-1 tree
    for (int i = 0; i < (1 << (2*WT+1)); i++) begin
      logic [WT-1:0] x, y;
      logic c;
      x = WT'(i); y = WT'(i >> WT); c = 1'(i >> (2*WT));
      @(posedge clk);
      at = x; bt = y; cit = c;
      @(negedge clk);
      check("R6 leaf-1 exhaustive", {{(W-WT){1'b0}}, cot, st},
            (W+1)'({1'b0, x} + {1'b0, y} + (WT+1)'(c)));
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule